// File: doc/BRIEF.md
# Scan Test Sequencer with Input and Output Scan Registers

This block places a small combinational circuit under test between two scan registers: one feeding the circuit's inputs and one capturing its outputs. Every cell of both registers is a flip-flop with a two-way multiplexer in front of it. A mode signal selects between functional data and the serial test path. When no test session is open, the block works as an ordinary two-stage pipeline. Functional inputs are registered, passed through the logic, and registered again.

A test session is a series of operations, each started with a start pulse and an operation code. A flush operation checks the chains themselves by pushing a fixed pattern through both registers. An apply operation takes a 5-bit vector. It shifts the vector's upper four bits into the input register and holds the lowest bit on a controllable primary input. It then runs one capture cycle with the mode signal low. The response stays in the output register until the next operation, which shifts it out while the new vector shifts in. A drain operation unloads the last response and closes the session. Each operation ends with a one-cycle done pulse, with the collected response on a parallel port.

Top module: `scan_test_seq`

## Requirements
- R1: With no session open, `ntModeO` is 0. The input register loads `funcInI` on every edge, and the output register loads the circuit's outputs. A value on `funcInI`/`funcPiI` therefore appears as the circuit result on `funcOutO` after two rising edges.
- R2: The circuit under test maps inputs a[3:0] and primary input p to y[0]=a[0]^a[1], y[1]=a[1]&a[2], y[2]=a[2]|a[3], y[3]=a[3]^p. Examples: vector a=0110,p=0 gives 0111, and a=1101,p=1 gives 0101.
- R3: Operation code 2'b00 (apply) loads input-register bits a[3:0]=vecI[4:1] and holds p=vecI[0]. It drives `ntModeO` high for exactly 4 cycles, and during them `scanInO` carries vecI[4], vecI[3], vecI[2], vecI[1] in that order.
- R4: After the last apply shift comes exactly one capture cycle with `ntModeO`=0. `doneO` rises in the next cycle. Counting the cycle after the start edge as cycle 1, done is high in cycle 6.
- R5: During the shift cycles of an apply, `scanOutO` emits the previously held response bit 3 first. At done, `respO` equals that previous response.
- R6: `doneO` is high for exactly one cycle per accepted operation. `busyO` is high from the cycle after the start edge until done, and low after done.
- R7: Operation code 2'b01 (flush) shifts the repeating pattern 0,0,1,1 for 12 cycles with no capture. Done comes in cycle 13. `respO` then reads 0011, and the output register (`funcOutO`) also holds 0011.
- R8: Operation code 2'b10 (drain) shifts 4 cycles with `scanInO`=0 and then signals done in cycle 5. `respO` holds the last captured response. The session then closes, and R1 behaviour resumes.
- R9: Inside an open session and between operations, both registers hold their contents. Changes on `funcInI`/`funcPiI` do not alter `funcOutO` or later responses.
- R10: A start pulse while busy is ignored, and so is operation code 2'b11. In both cases no extra done appears, and the running result is unchanged.
- R11: After reset the block is idle with the session closed. All register contents are 0, and `busyO`, `doneO`, `ntModeO`, `respO` and `funcOutO` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startI | input | 1 | Start an operation (sampled when idle) |
| opI | input | 2 | Operation: 00 apply, 01 flush, 10 drain, 11 reserved |
| vecI | input | 5 | Test vector: [4:1] chain bits, [0] primary-input bit |
| funcInI | input | 4 | Functional data into the input register |
| funcPiI | input | 1 | Functional primary input of the circuit |
| funcOutO | output | 4 | Output register contents |
| scanInO | output | 1 | Serial bit entering the input register |
| scanOutO | output | 1 | Serial bit leaving the output register |
| ntModeO | output | 1 | Cell mode: 1 shift, 0 functional load |
| busyO | output | 1 | Operation in progress |
| doneO | output | 1 | One-cycle operation-complete pulse |
| respO | output | 4 | Response collected by the last unload |

## Verification
A corrupted cell or a broken link between the two registers shows up as a wrong `respO` at the done pulse of the next operation. It also shows on `funcOutO` while a session idles. The flush pattern exposes it within 13 cycles, before any vector is used. A sequencer that miscounts shifts or repeats the capture moves the done pulse away from cycle 6 (apply), 5 (drain) or 13 (flush), or changes how many cycles `ntModeO` stays high. It also scrambles the serial bit order seen on `scanInO` and `scanOutO`. A failure to hold between operations replaces the held response with functional data, so the next unload reads the wrong value.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [1:0] {
    OP_APPLY = 2'b00,
    OP_FLUSH = 2'b01,
    OP_DRAIN = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_CAPT,
    ST_DONE
  } st_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic ntMode;    // 1: cells shift, 0: cells load functional data
    logic cellEn;    // cells update this edge
    logic loadPat;   // load the serial source register
    op_e  patSel;    // which source to load
    logic sessOpen;  // a test session is open
  } strobe_t;

endpackage

// File: rtl/scan_seq_reg.sv
module scan_seq_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ntMode,
  input  logic         cellEn,
  input  logic         sin,
  input  logic [W-1:0] funcD,
  output logic [W-1:0] q,
  output logic         sout
);

  logic [W-1:0] chainIn;
  assign chainIn = {q[W-2:0], sin};
  assign sout    = q[W-1];

  // one flop plus one 2:1 mux per cell
  for (genvar i = 0; i < W; i++) begin : g_cell
    logic dMux;
    assign dMux = ntMode ? chainIn[i] : funcD[i];
    always_ff @(posedge clk) begin
      if (!rstN)       q[i] <= 1'b0;
      else if (cellEn) q[i] <= dMux;
    end
  end

  a_r3_shift_moves : assert property (@(posedge clk) disable iff (!rstN)
    (ntMode && cellEn) |=> (q == $past({q[W-2:0], sin})));

  a_r9_hold_stable : assert property (@(posedge clk) disable iff (!rstN)
    !cellEn |=> $stable(q));

endmodule

// File: rtl/scan_seq_cut.sv
module scan_seq_cut #(
  parameter int CW = 4,
  parameter int PW = 1
) (
  input  logic [CW-1:0] a,
  input  logic [PW-1:0] p,
  output logic [CW-1:0] y
);

  for (genvar i = 0; i < CW - 1; i++) begin : g_gate
    if (i % 3 == 0) begin : g_xor
      assign y[i] = a[i] ^ a[i+1];
    end else if (i % 3 == 1) begin : g_and
      assign y[i] = a[i] & a[i+1];
    end else begin : g_or
      assign y[i] = a[i] | a[i+1];
    end
  end

  assign y[CW-1] = a[CW-1] ^ (^p);

endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startI,
  input  logic [1:0] opI,
  output strobe_t    stb,
  output logic       busyO,
  output logic       doneO
);

  localparam int FLUSH_SHIFTS = 3 * CW;
  localparam int CNT_W        = $clog2(FLUSH_SHIFTS + 1);

  st_e              state;
  op_e              opQ;
  logic             sessQ;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;
  logic             go;
  op_e              opIn;

  assign opIn    = op_e'(opI);
  assign go      = (state == ST_IDLE) && startI && (opIn != OP_RSVD);
  assign lastCnt = (opQ == OP_FLUSH) ? CNT_W'(FLUSH_SHIFTS - 1) : CNT_W'(CW - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opQ   <= OP_APPLY;
      sessQ <= 1'b0;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (go) begin
          opQ   <= opIn;
          sessQ <= 1'b1;
          cnt   <= '0;
          state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          cnt <= cnt + 1'b1;
          if (cnt == lastCnt) state <= (opQ == OP_APPLY) ? ST_CAPT : ST_DONE;
        end
        ST_CAPT: state <= ST_DONE;
        ST_DONE: begin
          state <= ST_IDLE;
          if (opQ == OP_DRAIN) sessQ <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.ntMode   = (state == ST_SHIFT);
    stb.cellEn   = (state == ST_SHIFT) || (state == ST_CAPT) || !sessQ;
    stb.loadPat  = go;
    stb.patSel   = opIn;
    stb.sessOpen = sessQ;
  end

  assign busyO = (state != ST_IDLE);
  assign doneO = (state == ST_DONE);

  a_r6_done_pulse : assert property (@(posedge clk) disable iff (!rstN)
    doneO |=> !doneO);

  a_r4_one_capture : assert property (@(posedge clk) disable iff (!rstN)
    ($fell(stb.ntMode) && opQ == OP_APPLY) |=> doneO);

  a_r10_busy_ignores : assert property (@(posedge clk) disable iff (!rstN)
    (busyO && startI) |=> $stable(opQ));

  a_r8_drain_closes : assert property (@(posedge clk) disable iff (!rstN)
    (doneO && opQ == OP_DRAIN) |=> !stb.sessOpen);

endmodule

// File: rtl/scan_seq_dp.sv
module scan_seq_dp
  import scan_seq_pkg::*;
#(
  parameter int CW = 4,
  parameter int PW = 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        stb,
  input  logic [CW+PW-1:0] vecI,
  input  logic [CW-1:0]  funcInI,
  input  logic [PW-1:0]  funcPiI,
  output logic [CW-1:0]  funcOutO,
  output logic           scanInO,
  output logic           scanOutO,
  output logic [CW-1:0]  respO
);

  localparam int VW = CW + PW;
  localparam logic [CW-1:0] FLUSH_PAT = {{(CW - CW / 2){1'b0}}, {(CW / 2){1'b1}}};

  logic [CW-1:0] srcSh;
  logic [PW-1:0] piHold;
  logic [PW-1:0] cutPi;
  logic [CW-1:0] inQ;
  logic [CW-1:0] cutY;
  logic          inSout;
  logic [CW-1:0] respCol;

  // serial source: vector, flush pattern or zeros, rotated each shift
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSh  <= '0;
      piHold <= '0;
    end else if (stb.loadPat) begin
      unique case (stb.patSel)
        OP_APPLY: srcSh <= vecI[VW-1:PW];
        OP_FLUSH: srcSh <= FLUSH_PAT;
        default:  srcSh <= '0;
      endcase
      if (stb.patSel == OP_APPLY) piHold <= vecI[PW-1:0];
    end else if (stb.ntMode) begin
      srcSh <= {srcSh[CW-2:0], srcSh[CW-1]};
    end
  end

  assign scanInO = srcSh[CW-1];
  assign cutPi   = stb.sessOpen ? piHold : funcPiI;

  scan_seq_reg #(.W(CW)) u_inReg (
    .clk   (clk),
    .rstN  (rstN),
    .ntMode(stb.ntMode),
    .cellEn(stb.cellEn),
    .sin   (scanInO),
    .funcD (funcInI),
    .q     (inQ),
    .sout  (inSout)
  );

  scan_seq_cut #(.CW(CW), .PW(PW)) u_cut (
    .a(inQ),
    .p(cutPi),
    .y(cutY)
  );

  scan_seq_reg #(.W(CW)) u_outReg (
    .clk   (clk),
    .rstN  (rstN),
    .ntMode(stb.ntMode),
    .cellEn(stb.cellEn),
    .sin   (inSout),
    .funcD (cutY),
    .q     (funcOutO),
    .sout  (scanOutO)
  );

  // unload collector: first bit out lands in the top position
  always_ff @(posedge clk) begin
    if (!rstN)           respCol <= '0;
    else if (stb.ntMode) respCol <= {respCol[CW-2:0], scanOutO};
  end

  assign respO = respCol;

  a_r5_collect : assert property (@(posedge clk) disable iff (!rstN)
    stb.ntMode |=> (respO[0] == $past(scanOutO)));

  a_r9_pi_held : assert property (@(posedge clk) disable iff (!rstN)
    (stb.sessOpen && !stb.loadPat) |=> $stable(piHold));

endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq
  import scan_seq_pkg::*;
#(
  parameter int CW = 4,
  parameter int PW = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startI,
  input  logic [1:0]       opI,
  input  logic [CW+PW-1:0] vecI,
  input  logic [CW-1:0]    funcInI,
  input  logic [PW-1:0]    funcPiI,
  output logic [CW-1:0]    funcOutO,
  output logic             scanInO,
  output logic             scanOutO,
  output logic             ntModeO,
  output logic             busyO,
  output logic             doneO,
  output logic [CW-1:0]    respO
);

  strobe_t stb;

  scan_seq_ctrl #(.CW(CW)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .startI(startI),
    .opI   (opI),
    .stb   (stb),
    .busyO (busyO),
    .doneO (doneO)
  );

  scan_seq_dp #(.CW(CW), .PW(PW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .vecI    (vecI),
    .funcInI (funcInI),
    .funcPiI (funcPiI),
    .funcOutO(funcOutO),
    .scanInO (scanInO),
    .scanOutO(scanOutO),
    .respO   (respO)
  );

  assign ntModeO = stb.ntMode;

  a_r1_idle_mode_low : assert property (@(posedge clk) disable iff (!rstN)
    !busyO |-> !ntModeO);

endmodule

// File: tb/scan_test_seq_bench.sv
module scan_test_seq_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startI = 1'b0;
  logic [1:0] opI = 2'b00;
  logic [4:0] vecI = '0;
  logic [3:0] funcInI = '0;
  logic [0:0] funcPiI = '0;
  logic [3:0] funcOutO;
  logic       scanInO, scanOutO, ntModeO, busyO, doneO;
  logic [3:0] respO;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  scan_test_seq u_scan_test_seq (
    .clk(clk), .rstN(rstN), .startI(startI), .opI(opI), .vecI(vecI),
    .funcInI(funcInI), .funcPiI(funcPiI), .funcOutO(funcOutO),
    .scanInO(scanInO), .scanOutO(scanOutO), .ntModeO(ntModeO),
    .busyO(busyO), .doneO(doneO), .respO(respO)
  );

  // {vector[4:0], expected circuit response[3:0]} from the R2 equations
  localparam int NV = 5;
  localparam logic [8:0] TBL [NV] = '{
    {5'b01100, 4'b0111},
    {5'b11011, 4'b0101},
    {5'b10101, 4'b0101},
    {5'b00111, 4'b1000},
    {5'b11110, 4'b1110}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // start an operation and follow it cycle by cycle until done
  task automatic runOp(input logic [1:0] op, input logic [4:0] vec, input int expLat,
                       input logic [3:0] expResp, input bit poke, input string tag);
    int lat = 0;
    int shifts = 0;
    bit seqOk = 1'b1;
    @(negedge clk);
    opI = op; vecI = vec; startI = 1'b1;
    @(negedge clk);
    startI = 1'b0;
    for (int n = 1; n <= 40; n++) begin
      if (ntModeO) begin
        shifts++;
        if (op != 2'b01 && n <= 4) begin
          if (scanOutO !== expResp[4-n]) seqOk = 1'b0;
          if (op == 2'b00 && scanInO !== vec[5-n]) seqOk = 1'b0;
          if (op == 2'b10 && scanInO !== 1'b0) seqOk = 1'b0;
        end
      end
      if (n == 1) chk(busyO === 1'b1, {tag, " R6 busy after start"}, busyO, 1);
      if (doneO) begin
        lat = n;
        break;
      end
      if (poke && n == 2) begin startI = 1'b1; opI = 2'b01; vecI = ~vec; end
      else startI = 1'b0;
      @(negedge clk);
    end
    startI = 1'b0;
    chk(lat == expLat, {tag, " R4 done cycle"}, lat, expLat);
    chk(shifts == ((op == 2'b01) ? 12 : 4), {tag, " R3 shift cycles"}, shifts,
        (op == 2'b01) ? 12 : 4);
    chk(respO === expResp, {tag, " R5 response"}, respO, expResp);
    if (op != 2'b01) chk(seqOk, {tag, " R3 R5 serial order"}, seqOk, 1);
    @(negedge clk);
    chk(doneO === 1'b0 && busyO === 1'b0, {tag, " R6 single done"}, {doneO, busyO}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [3:0] prev;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(busyO === 0 && doneO === 0 && ntModeO === 0, "R11 idle flags",
        {busyO, doneO, ntModeO}, 0);
    chk(respO === 4'b0, "R11 respO", respO, 0);

    // R1 / R2 functional pipeline
    for (int i = 0; i < 3; i++) begin
      funcInI = TBL[i][8:5];
      funcPiI = TBL[i][4];
      @(negedge clk); @(negedge clk);
      chk(funcOutO === TBL[i][3:0], "R1 R2 functional result", funcOutO, TBL[i][3:0]);
      chk(ntModeO === 1'b0, "R1 mode low", ntModeO, 0);
    end

    // R7 flush
    runOp(2'b01, 5'b0, 13, 4'b0011, 1'b0, "R7 flush");
    chk(funcOutO === 4'b0011, "R7 output register after flush", funcOutO, 4'b0011);

    // apply the table, each response unloaded by the next operation
    prev = 4'b0011;
    for (int i = 0; i < NV; i++) begin
      runOp(2'b00, TBL[i][8:4], 6, prev, (i == 1), "R3 R10 apply");
      prev = TBL[i][3:0];
      // R9 hold between operations
      for (int k = 0; k < 4; k++) begin
        funcInI = 4'(k * 5 + i); funcPiI = 1'(k);
        @(negedge clk);
        chk(funcOutO === prev, "R9 held response", funcOutO, prev);
      end
    end

    // R10 reserved code
    @(negedge clk); opI = 2'b11; startI = 1'b1;
    @(negedge clk); startI = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk(busyO === 0 && doneO === 0, "R10 reserved op ignored", {busyO, doneO}, 0);
      @(negedge clk);
    end
    chk(funcOutO === prev, "R10 state kept", funcOutO, prev);

    // R8 drain, then functional mode again
    runOp(2'b10, 5'b0, 5, prev, 1'b0, "R8 drain");
    funcInI = 4'b1101; funcPiI = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(funcOutO === 4'b0101, "R8 R1 session closed", funcOutO, 4'b0101);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule